// File: doc/BRIEF.md
# Flash Instruction Fetch Accelerator

This block sits between the instruction fetch port of a 32-bit processor and a slow flash array that delivers a full 128-bit line on each read. The line buffers inside the block answer most fetches, so the processor waits only when the line it needs is held in none of them. The block keeps three buffers. The current buffer holds the line the processor is executing from. The look-ahead buffer holds the next sequential line, which the block reads from flash while the current line is being consumed. The return buffer holds the line most recently reached through a demand miss, so that a loop whose backward branch lands in that line pays no flash wait when it runs again.

The processor raises `cpu_req` with a word address and holds both until `cpu_ready` is high. Two small registers control the block. A 2-bit operating level chooses between no buffering, sequential buffering only, and full buffering. A 3-bit wait setting gives the number of clock cycles that one flash line read takes.

Top module: `flash_fetch_accel`

## Requirements
- R1: `cpu_word_addr` counts 32-bit words. Its two low bits select the word within a line, and word w sits in bits [32w+31:32w] of `flash_rdata`. The remaining upper bits form the line number that is driven on `flash_line`.
- R2: A fetch that misses every buffer while the flash port is idle starts a line read in the same cycle. `cpu_ready` then rises T+1 cycles after the request was first presented, where T is the effective wait setting, and it returns the addressed word.
- R3: While buffering is on (level 1 or 2), a fetch to any word of a line already in the current buffer gets `cpu_ready` in the same cycle, with no stall.
- R4: While buffering is on, after the block has taken a line into the current buffer it reads the following line on its own into the look-ahead buffer. Once that read has ended, a fetch to the following line is served with no stall. A fetch presented the cycle after the current line's first hit stalls exactly T cycles.
- R5: At level 2, every line brought in by a demand miss is also kept in the return buffer. A later fetch to that line is served with no stall, even after execution has moved on to other lines.
- R6: At level 1 the return buffer is never used. A fetch back to an earlier line that is no longer current or look-ahead behaves as an R2 miss.
- R7: At level 0 every fetch, including a repeat of the same address, behaves as an R2 miss. The line read on a miss serves exactly one fetch.
- R8: Only one flash read is in progress at a time. `flash_line` stays stable until the read ends, and `flash_rd` is low for at least one cycle between reads. A demand miss that arrives in the cycle a look-ahead read would otherwise start takes the flash port instead.
- R9: The wait setting resets to 3 and accepts 1 to 7, and the value 0 acts as 1. The operating level resets to 2, and the value 3 acts as 2.
- R10: A write to either control register clears all three buffers and cancels any flash read in progress. The next fetch therefore behaves as an R2 miss.
- R11: `cpu_ready` is never high while `cpu_req` is low.
- R12: While reset is held, `cpu_ready` and `flash_rd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Fetch request, held until ready |
| cpu_word_addr | input | ADDR_W-2 | Word address of the fetch |
| cpu_ready | output | 1 | Fetch served this cycle |
| cpu_rdata | output | 32 | Fetched instruction word |
| mode_wr | input | 1 | Write strobe for the operating level |
| mode_wdata | input | 2 | New operating level |
| tim_wr | input | 1 | Write strobe for the wait setting |
| tim_wdata | input | 3 | New flash wait setting in cycles |
| flash_rd | output | 1 | Flash line read in progress |
| flash_line | output | ADDR_W-4 | Line number being read |
| flash_rdata | input | 128 | Line data from the flash array |

## Verification
A stale valid bit or a wrong tag in any buffer shows up directly on `cpu_rdata`, with a word from a different line, in the very cycle `cpu_ready` rises. A buffer that drops a line it should have kept shows up instead as a stall count of T+1 or T where zero was due. A faulty wait counter or a wrong read order changes the stall length of the next miss by whole cycles. Sweeping all three operating levels against every wait setting, with sequential, backward and back-to-back miss patterns, therefore exposes each such fault at the first affected fetch.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
  localparam int WORD_W   = 32;
  localparam int WPL      = 4;
  localparam int LINE_W   = WORD_W * WPL;
  localparam int SEL_W    = $clog2(WPL);
  localparam int TIM_W    = 3;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,
    LVL_SEQ  = 2'd1,
    LVL_FULL = 2'd2
  } level_e;

  // wait setting 0 behaves as a single cycle
  function automatic logic [TIM_W-1:0] eff_cycles(input logic [TIM_W-1:0] t);
    return (t == '0) ? TIM_W'(1) : t;
  endfunction

  // encoding 3 is folded onto full buffering
  function automatic level_e norm_level(input logic [1:0] v);
    return (v == 2'd3) ? LVL_FULL : level_e'(v);
  endfunction

  function automatic logic [WORD_W-1:0] word_pick(input logic [LINE_W-1:0] line,
                                                  input logic [SEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/ffa_line_buf.sv
module ffa_line_buf #(
  parameter int TAG_W  = 28,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              drop,
  input  logic              ld,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_data,
  output logic              q_valid,
  output logic [TAG_W-1:0]  q_tag,
  output logic [DATA_W-1:0] q_data
);
  // flush beats load, load beats drop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_data  <= '0;
    end else if (flush) begin
      q_valid <= 1'b0;
    end else if (ld) begin
      q_valid <= 1'b1;
      q_tag   <= ld_tag;
      q_data  <= ld_data;
    end else if (drop) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ffa_flash_seq.sv
module ffa_flash_seq #(
  parameter int TAG_W = 28,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic             start_dem,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy,
  output logic [TAG_W-1:0] line,
  output logic             is_dem,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      line   <= '0;
      is_dem <= 1'b0;
    end else if (cancel) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= cycles - CNT_W'(1);
      line   <= start_tag;
      is_dem <= start_dem;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/flash_fetch_accel.sv
module flash_fetch_accel
  import ffa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic [ADDR_W-3:0]    cpu_word_addr,
  output logic                 cpu_ready,
  output logic [WORD_W-1:0]    cpu_rdata,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_wdata,
  input  logic                 tim_wr,
  input  logic [TIM_W-1:0]     tim_wdata,
  output logic                 flash_rd,
  output logic [ADDR_W-5:0]    flash_line,
  input  logic [LINE_W-1:0]    flash_rdata
);
  localparam int LA_W = ADDR_W - 4;

  level_e           mode_q;
  logic [TIM_W-1:0] tim_q;
  logic             cfg_wr;

  assign cfg_wr = mode_wr || tim_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LVL_FULL;
      tim_q  <= TIM_W'(3);
    end else begin
      if (mode_wr) mode_q <= norm_level(mode_wdata);
      if (tim_wr)  tim_q  <= tim_wdata;
    end
  end

  logic [LA_W-1:0]  req_tag;
  logic [SEL_W-1:0] req_sel;
  assign req_tag = cpu_word_addr[ADDR_W-3:SEL_W];
  assign req_sel = cpu_word_addr[SEL_W-1:0];

  // buffer state
  logic              c_valid, p_valid, b_valid;
  logic [LA_W-1:0]   c_tag, p_tag, b_tag;
  logic [LINE_W-1:0] c_data, p_data, b_data;

  // named events, also seen by the checker
  logic hit_c, hit_p, hit_b, any_hit;
  logic serve_c, serve_p, serve_b;
  logic dem_miss, start_dem, start_pf, want_pf;
  logic rd_busy, rd_isdem, rd_done, dem_done, pf_done;
  logic [LA_W-1:0] rd_line, nxt_tag, st_tag;

  assign hit_c   = c_valid && (c_tag == req_tag);
  assign hit_p   = p_valid && (p_tag == req_tag) && (mode_q != LVL_OFF);
  assign hit_b   = b_valid && (b_tag == req_tag) && (mode_q == LVL_FULL);
  assign any_hit = hit_c || hit_p || hit_b;

  assign serve_c = cpu_req && hit_c;
  assign serve_p = cpu_req && !hit_c && hit_p;
  assign serve_b = cpu_req && !hit_c && !hit_p && hit_b;

  assign cpu_ready = cpu_req && any_hit;

  always_comb begin
    if (hit_c)      cpu_rdata = word_pick(c_data, req_sel);
    else if (hit_p) cpu_rdata = word_pick(p_data, req_sel);
    else            cpu_rdata = word_pick(b_data, req_sel);
  end

  assign nxt_tag   = c_tag + {{(LA_W-1){1'b0}}, 1'b1};
  assign dem_miss  = cpu_req && !any_hit;
  assign want_pf   = (mode_q != LVL_OFF) && c_valid && !(p_valid && (p_tag == nxt_tag));
  assign start_dem = dem_miss && !rd_busy && !cfg_wr;
  assign start_pf  = !dem_miss && want_pf && !rd_busy && !cfg_wr;
  assign st_tag    = start_dem ? req_tag : nxt_tag;
  assign dem_done  = rd_done && rd_isdem;
  assign pf_done   = rd_done && !rd_isdem;

  ffa_flash_seq #(.TAG_W(LA_W), .CNT_W(TIM_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cancel    (cfg_wr),
    .start     (start_dem || start_pf),
    .start_tag (st_tag),
    .start_dem (start_dem),
    .cycles    (eff_cycles(tim_q)),
    .busy      (rd_busy),
    .line      (rd_line),
    .is_dem    (rd_isdem),
    .done      (rd_done)
  );

  assign flash_rd   = rd_busy;
  assign flash_line = rd_line;

  // current line: filled by a demand read, a look-ahead promotion or a return-buffer hit
  logic              c_ld;
  logic [LA_W-1:0]   c_ld_tag;
  logic [LINE_W-1:0] c_ld_data;

  assign c_ld = dem_done || serve_p || serve_b;
  always_comb begin
    if (dem_done) begin
      c_ld_tag  = rd_line;
      c_ld_data = flash_rdata;
    end else if (serve_p) begin
      c_ld_tag  = p_tag;
      c_ld_data = p_data;
    end else begin
      c_ld_tag  = b_tag;
      c_ld_data = b_data;
    end
  end

  ffa_line_buf #(.TAG_W(LA_W), .DATA_W(LINE_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .flush(cfg_wr),
    .drop(serve_c && (mode_q == LVL_OFF)),
    .ld(c_ld), .ld_tag(c_ld_tag), .ld_data(c_ld_data),
    .q_valid(c_valid), .q_tag(c_tag), .q_data(c_data)
  );

  ffa_line_buf #(.TAG_W(LA_W), .DATA_W(LINE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .flush(cfg_wr),
    .drop(serve_p),
    .ld(pf_done), .ld_tag(rd_line), .ld_data(flash_rdata),
    .q_valid(p_valid), .q_tag(p_tag), .q_data(p_data)
  );

  ffa_line_buf #(.TAG_W(LA_W), .DATA_W(LINE_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .flush(cfg_wr),
    .drop(1'b0),
    .ld(dem_done && (mode_q == LVL_FULL)), .ld_tag(rd_line), .ld_data(flash_rdata),
    .q_valid(b_valid), .q_tag(b_tag), .q_data(b_data)
  );
endmodule

// File: rtl/ffa_checker.sv
module ffa_checker
  import ffa_pkg::*;
#(
  parameter int LA_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_ready,
  input logic             flash_rd,
  input logic [LA_W-1:0]  flash_line,
  input logic             rd_done,
  input logic             dem_done,
  input logic             cfg_wr,
  input level_e           mode_q,
  input logic [TIM_W-1:0] tim_q
);
  logic [3:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (!flash_rd) run_cnt <= '0;
    else               run_cnt <= run_cnt + 4'd1;
  end

  a_r11_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r8_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rd && !rd_done && !cfg_wr) |=> (flash_rd && $stable(flash_line)));

  a_r8_gap_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !flash_rd);

  a_r9_read_length: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> ((run_cnt + 4'd1) == {1'b0, eff_cycles(tim_q)}));

  a_r7_off_serves_fresh_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && (mode_q == LVL_OFF)) |-> $past(dem_done));
endmodule

bind flash_fetch_accel ffa_checker #(.LA_W(ADDR_W - 4)) u_ffa_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .flash_rd(flash_rd), .flash_line(flash_line), .rd_done(rd_done),
  .dem_done(dem_done), .cfg_wr(cfg_wr), .mode_q(mode_q), .tim_q(tim_q)
);

// File: tb/test_flash_fetch_accel.sv
module test_flash_fetch_accel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0;
  logic [29:0]  cpu_word_addr = '0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mode_wr = 1'b0;
  logic [1:0]   mode_wdata = '0;
  logic         tim_wr = 1'b0;
  logic [2:0]   tim_wdata = '0;
  logic         flash_rd;
  logic [27:0]  flash_line;
  logic [127:0] flash_rdata;

  int checks = 0;
  int fails  = 0;
  int stalls;
  logic [27:0] seen_line;
  logic [31:0] got_data;

  always #5 clk = ~clk;

  flash_fetch_accel i_flash_fetch_accel (.*);

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return 32'hC300_0000 | {8'h00, a[23:2], 2'b00};
  endfunction

  always_comb begin
    for (int w = 0; w < 4; w++)
      flash_rdata[w*32 +: 32] = word_of({flash_line, w[1:0], 2'b00});
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_word_addr = a[31:2];
    stalls = 0;
    seen_line = '1;
    forever begin
      #1;
      if (flash_rd && stalls == 1) seen_line = flash_line;
      if (cpu_ready) break;
      if (stalls > 60) begin
        fails++; checks++;
        $display("FAIL R2 actual=hang expected=ready");
        break;
      end
      @(negedge clk);
      stalls++;
    end
    got_data = cpu_rdata;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic wr_cfg(input logic [1:0] m, input logic [2:0] t, input bit dm, input bit dt);
    @(negedge clk);
    cpu_req = 1'b0;
    mode_wr = dm; mode_wdata = m;
    tim_wr = dt;  tim_wdata = t;
    @(negedge clk);
    mode_wr = 1'b0; tim_wr = 1'b0;
  endtask

  initial begin
    #100000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 ready in reset", int'(cpu_ready), 0);
    chk("R12 flash_rd in reset", int'(flash_rd), 0);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset values: level 2, wait 3
    fetch(32'h0000_0040);
    chk("R9 reset wait gives 4 stalls", stalls, 4);
    chk("R1 word data", int'(got_data), int'(word_of(32'h40)));
    idle(12);
    fetch(32'h0000_0050);
    chk("R4 reset level prefetches", stalls, 0);

    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 8; t++) begin
        automatic int te = (t == 0) ? 1 : t;
        automatic int lv = (m == 3) ? 2 : m;
        automatic logic [31:0] base = 32'h0001_0000 + m * 32'h1000 + t * 32'h100;
        automatic logic [31:0] far  = base + 32'h80;
        automatic logic [31:0] oth  = base + 32'hC0;
        wr_cfg(m[1:0], t[2:0], 1'b1, 1'b1);

        fetch(base);
        chk("R2 cold miss stall", stalls, te + 1);
        chk("R1 miss line on flash port", int'(seen_line), int'(base[31:4]));
        chk("R1 miss word", int'(got_data), int'(word_of(base)));
        for (int w = 1; w < 4; w++) begin
          fetch(base + w * 4);
          chk(lv == 0 ? "R7 repeat line misses" : "R3 same line hit", stalls, lv == 0 ? te + 1 : 0);
          chk("R1 word select", int'(got_data), int'(word_of(base + w * 4)));
        end
        idle(12);
        fetch(base + 32'h14);
        chk(lv == 0 ? "R7 next line misses" : "R4 next line prefetched", stalls, lv == 0 ? te + 1 : 0);
        chk("R4 next line word", int'(got_data), int'(word_of(base + 32'h14)));
        idle(12);
        fetch(base + 32'h8);
        chk(lv == 2 ? "R5 return buffer hit" : "R6 backward fetch misses", stalls, lv == 2 ? 0 : te + 1);
        chk("R5 return word", int'(got_data), int'(word_of(base + 32'h8)));

        idle(12);
        fetch(far);
        chk("R2 far miss", stalls, te + 1);
        fetch(far + 32'h10);
        chk(lv == 0 ? "R7 follow-on misses" : "R4 wait on inflight prefetch", stalls, lv == 0 ? te + 1 : te);
        chk("R4 inflight word", int'(got_data), int'(word_of(far + 32'h10)));
        fetch(oth);
        chk("R8 demand beats new prefetch", stalls, te + 1);
        chk("R8 demand word", int'(got_data), int'(word_of(oth)));

        wr_cfg(m[1:0], t[2:0], 1'b1, 1'b0);
        fetch(oth + 4);
        chk("R10 level write clears buffers", stalls, te + 1);
        idle(12);
        wr_cfg(m[1:0], t[2:0], 1'b0, 1'b1);
        fetch(oth + 8);
        chk("R10 wait write clears buffers", stalls, te + 1);
        idle(2);
        #1;
        chk("R11 no ready without request", int'(cpu_ready), 0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule